// File: doc/BRIEF.md
# Nibble-Split Hamming Stripe Codec

The block turns each byte into two 4-bit halves and protects each half with three Hamming check bits. The result is two 7-bit codewords per byte. Bit j of every codeword goes to drive lane j, so the seven lanes together hold one position of each codeword. The write path encodes one byte on every accepted cycle and places both codewords on the lane bus in the same cycle. Word 0 on the bus carries the low nibble and word 1 carries the high nibble.

The read path takes the same two-word lane layout back in. It applies a per-lane failure mask, computes a syndrome for each word, and repairs any single bad lane. It then puts the byte back together in the same low/high order. For each nibble it also reports whether a repair was made. A single lost lane never loses data: a lane flagged as failed is read as 0, and the syndrome rebuilds its true value.

Top module: `hnib_stripe`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, `wr_valid` and `out_valid` are low.
- R2: Lane-bus bit 7*t+j holds codeword position j+1 of nibble t, where t=0 is the low nibble. Check bits sit at positions 1, 2 and 4. Data bits d0..d3 sit at positions 3, 5, 6 and 7. Each check bit makes even the parity of all positions whose index has that check bit's weight set.
- R3: `in_ready` is always high. Every byte accepted on one clock edge appears encoded on `wr_lanes`, with `wr_valid` high, after that edge. This holds for back-to-back bytes with no gap.
- R4: A read word whose two codewords are both error-free returns the original byte with `out_corr` = 0.
- R5: A single flipped lane in a codeword is corrected. The byte is returned intact and `out_corr` bit t is set for each nibble t that was repaired.
- R6: A flipped check lane (position 1, 2 or 4) leaves the data bits unchanged and still sets that nibble's `out_corr` bit.
- R7: A lane whose `fail_mask` bit is set is read as 0, whatever is on the bus, and the byte is rebuilt. `out_corr` bit t is set exactly when nibble t's true bit on that lane was 1.
- R8: While `out_valid` is high and `out_ready` is low, `rd_ready` is low, and `out_byte` and `out_corr` hold their values.
- R9: A read word accepted on one edge (`rd_valid` and `rd_ready` both high) appears on `out_byte` with `out_valid` high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte to encode is present |
| in_ready | output | 1 | Encoder accepts a byte (always high) |
| in_byte | input | 8 | Byte to encode |
| wr_valid | output | 1 | Lane write word is valid |
| wr_lanes | output | 14 | Two 7-lane codewords, low nibble in bits 6:0 |
| rd_valid | input | 1 | Lane read word is present |
| rd_ready | output | 1 | Decoder accepts a read word |
| rd_lanes | input | 14 | Two 7-lane codewords read back |
| fail_mask | input | 7 | One bit per lane marking a failed drive |
| out_valid | output | 1 | Decoded byte is valid |
| out_ready | input | 1 | Consumer takes the decoded byte |
| out_byte | output | 8 | Repaired, reassembled byte |
| out_corr | output | 2 | Per-nibble flag: a repair was made |

## Verification
The bench flips every lane in turn, data lanes and check lanes alike, in both nibbles, on its own and in pairs across nibbles. A wrong syndrome-to-position map would flip the wrong bit and return a corrupted byte. A decoder that took check positions as data would corrupt a data bit on an R6 flip. Failed-lane cases put random garbage on the masked lane: a design that ignored the mask, or set the repair flag from the mask instead of the syndrome, would return wrong data or wrong flags. Back-to-back writes and a stalled output would expose a missing byte or an output that moves while it is held.

// File: rtl/hnib_pkg.sv
package hnib_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CW_W  = 7;
  localparam int unsigned SYN_W = 3;
  typedef logic [CW_W-1:0]  cw_t;
  typedef logic [SYN_W-1:0] syn_t;
endpackage

// File: rtl/hnib_enc.sv
module hnib_enc
  import hnib_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output cw_t              cw
);
  // position p sits at cw[p-1]; checks at 1,2,4
  always_comb begin
    cw[2] = nib[0];
    cw[4] = nib[1];
    cw[5] = nib[2];
    cw[6] = nib[3];
    cw[0] = nib[0] ^ nib[1] ^ nib[3];
    cw[1] = nib[0] ^ nib[2] ^ nib[3];
    cw[3] = nib[1] ^ nib[2] ^ nib[3];
  end
endmodule

// File: rtl/hnib_dec.sv
module hnib_dec
  import hnib_pkg::*;
(
  input  cw_t              rx,
  input  cw_t              erase,
  output logic [NIB_W-1:0] nib,
  output logic             fixed
);
  cw_t  masked;
  cw_t  flip;
  cw_t  repaired;
  syn_t syn;

  always_comb begin
    masked = rx & ~erase;
    syn[0] = masked[0] ^ masked[2] ^ masked[4] ^ masked[6];
    syn[1] = masked[1] ^ masked[2] ^ masked[5] ^ masked[6];
    syn[2] = masked[3] ^ masked[4] ^ masked[5] ^ masked[6];
    flip   = '0;
    if (syn != '0) flip[syn - syn_t'(1)] = 1'b1;
    repaired = masked ^ flip;
    nib   = {repaired[6], repaired[5], repaired[4], repaired[2]};
    fixed = (syn != '0);
  end
endmodule

// File: rtl/hnib_stripe.sv
module hnib_stripe
  import hnib_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIBS   = DATA_W / NIB_W,
  localparam int unsigned LANE_W = NIBS * CW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_byte,
  output logic              wr_valid,
  output logic [LANE_W-1:0] wr_lanes,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [LANE_W-1:0] rd_lanes,
  input  logic [CW_W-1:0]   fail_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic [NIBS-1:0]   out_corr
);
  logic [LANE_W-1:0] enc_lanes;
  logic [DATA_W-1:0] dec_byte;
  logic [NIBS-1:0]   dec_corr;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    hnib_enc u_enc (
      .nib (in_byte[NIB_W*g +: NIB_W]),
      .cw  (enc_lanes[CW_W*g +: CW_W])
    );
    hnib_dec u_dec (
      .rx    (rd_lanes[CW_W*g +: CW_W]),
      .erase (fail_mask),
      .nib   (dec_byte[NIB_W*g +: NIB_W]),
      .fixed (dec_corr[g])
    );
  end

  // write side
  logic              wr_valid_q, wr_valid_d;
  logic [LANE_W-1:0] wr_lanes_q, wr_lanes_d;
  logic              wr_load;

  assign in_ready = 1'b1;

  always_comb begin
    wr_load    = in_valid && in_ready;
    wr_valid_d = wr_load;
    wr_lanes_d = wr_load ? enc_lanes : wr_lanes_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_valid_q <= 1'b0;
    else        wr_valid_q <= wr_valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_load) wr_lanes_q <= wr_lanes_d;
  end

  assign wr_valid = wr_valid_q;
  assign wr_lanes = wr_lanes_q;

  // read side
  logic              out_valid_q, out_valid_d;
  logic [DATA_W-1:0] out_byte_q,  out_byte_d;
  logic [NIBS-1:0]   out_corr_q,  out_corr_d;
  logic              rd_take;

  always_comb begin
    rd_ready    = !out_valid_q || out_ready;
    rd_take     = rd_valid && rd_ready;
    out_valid_d = rd_take || (out_valid_q && !out_ready);
    out_byte_d  = rd_take ? dec_byte : out_byte_q;
    out_corr_d  = rd_take ? dec_corr : out_corr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= out_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rd_take) begin
      out_byte_q <= out_byte_d;
      out_corr_q <= out_corr_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_byte  = out_byte_q;
  assign out_corr  = out_corr_q;
endmodule

// File: rtl/hnib_stripe_chk.sv
module hnib_stripe_chk
  import hnib_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIBS   = DATA_W / NIB_W,
  localparam int unsigned LANE_W = NIBS * CW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wr_valid,
  input logic [LANE_W-1:0] wr_lanes,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_byte,
  input logic [NIBS-1:0]   out_corr
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  function automatic logic [2:0] parity_of(input logic [6:0] w);
    logic [2:0] s;
    s = '0;
    for (int p = 1; p <= 7; p++) begin
      if (w[p-1]) s = s ^ 3'(p);
    end
    return s;
  endfunction

  // R3: each accepted byte shows up on the lane bus one edge later
  a_r3_write_follows: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    1'b1 |-> (wr_valid == $past(in_valid && in_ready)));

  // R9: an accepted read word is presented on the next cycle
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> out_valid);

  // R8: a stalled output stays put
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_corr)));

  // R2: every word written to the lanes is a valid codeword
  for (genvar g = 0; g < NIBS; g++) begin : g_par
    a_r2_clean_codeword: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (parity_of(wr_lanes[CW_W*g +: CW_W]) == 3'd0));
  end
endmodule

bind hnib_stripe hnib_stripe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .wr_valid  (wr_valid),
  .wr_lanes  (wr_lanes),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte),
  .out_corr  (out_corr)
);

// File: tb/hnib_stripe_bench.sv
module hnib_stripe_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_byte;
  logic        wr_valid;
  logic [13:0] wr_lanes;
  logic        rd_valid;
  logic        rd_ready;
  logic [13:0] rd_lanes;
  logic [6:0]  fail_mask;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_byte;
  logic [1:0]  out_corr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  hnib_stripe u_hnib_stripe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .wr_valid(wr_valid), .wr_lanes(wr_lanes),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_lanes(rd_lanes),
    .fail_mask(fail_mask),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_corr(out_corr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hamming(7,4): data into positions 3,5,6,7; check bit c makes even parity over positions having weight c
  function automatic logic [6:0] ref_enc(input logic [3:0] n);
    logic [6:0] w;
    int k;
    int dpos[4];
    dpos[0] = 3; dpos[1] = 5; dpos[2] = 6; dpos[3] = 7;
    w = '0;
    for (k = 0; k < 4; k++) w[dpos[k]-1] = n[k];
    for (int c = 1; c <= 4; c = c * 2) begin
      logic par;
      par = 1'b0;
      for (int q = 1; q <= 7; q++) if ((q & c) != 0 && q != c) par ^= w[q-1];
      w[c-1] = par;
    end
    return w;
  endfunction

  function automatic logic [13:0] ref_lanes(input logic [7:0] b);
    return {ref_enc(b[7:4]), ref_enc(b[3:0])};
  endfunction

  task automatic do_read(input logic [13:0] lanes, input logic [6:0] mask,
                         input logic [7:0] exp_b, input logic [1:0] exp_c, input string req);
    @(negedge clk);
    rd_valid  = 1'b1;
    rd_lanes  = lanes;
    fail_mask = mask;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b1, req, 32'(out_valid), 32'd1);
    chk(out_byte === exp_b, req, 32'(out_byte), 32'(exp_b));
    chk(out_corr === exp_c, req, 32'(out_corr), 32'(exp_c));
    rd_valid  = 1'b0;
    fail_mask = '0;
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0;
    rd_valid = 1'b0; rd_lanes = '0; fail_mask = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(wr_valid === 1'b0, "R1 wr_valid in reset", 32'(wr_valid), 0);
    chk(out_valid === 1'b0, "R1 out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_valid === 1'b0 && out_valid === 1'b0, "R1 idle after release",
        {30'd0, wr_valid, out_valid}, 0);

    // R2: directed layout, 0x01 -> low cw positions 1,2,3 set -> 0x07; high nibble 0 -> 0
    in_valid = 1'b1; in_byte = 8'h01;
    @(negedge clk);
    chk(wr_lanes === 14'h0007, "R2 layout of 0x01", 32'(wr_lanes), 32'h7);
    chk(in_ready === 1'b1, "R3 in_ready high", 32'(in_ready), 1);

    // R3 + R2: back-to-back random bytes, one per cycle
    for (int i = 0; i < 200; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      in_byte = b;
      @(negedge clk);
      chk(wr_valid === 1'b1, "R3 wr_valid back-to-back", 32'(wr_valid), 1);
      chk(wr_lanes === ref_lanes(b), "R2 encoded lanes", 32'(wr_lanes), 32'(ref_lanes(b)));
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(wr_valid === 1'b0, "R3 wr_valid drops when idle", 32'(wr_valid), 0);

    // R4: clean reads
    do_read(ref_lanes(8'h00), '0, 8'h00, 2'b00, "R4 clean 0x00");
    do_read(ref_lanes(8'hFF), '0, 8'hFF, 2'b00, "R4 clean 0xFF");

    // R5 / R6: every lane flipped, low nibble then high nibble
    for (int ln = 0; ln < 7; ln++) begin
      logic [7:0] b;
      string tag;
      b = 8'($urandom);
      tag = (ln == 0 || ln == 1 || ln == 3) ? "R6 check-lane flip" : "R5 data-lane flip";
      do_read(ref_lanes(b) ^ (14'd1 << ln), '0, b, 2'b01, tag);
      do_read(ref_lanes(b) ^ (14'd1 << (ln + 7)), '0, b, 2'b10, tag);
    end

    // R5: random single errors in both nibbles at once
    for (int i = 0; i < 60; i++) begin
      logic [7:0]  b;
      logic [13:0] l;
      int e0, e1;
      b = 8'($urandom);
      e0 = int'($urandom_range(7, 0));
      e1 = int'($urandom_range(7, 0));
      l = ref_lanes(b);
      if (e0 < 7) l[e0] = ~l[e0];
      if (e1 < 7) l[e1 + 7] = ~l[e1 + 7];
      do_read(l, '0, b, {e1 < 7, e0 < 7}, "R5 random lane errors");
    end

    // R7: failed lane carrying garbage
    for (int i = 0; i < 40; i++) begin
      logic [7:0]  b;
      logic [13:0] l, good;
      int fl;
      b = 8'($urandom);
      fl = int'($urandom_range(6, 0));
      good = ref_lanes(b);
      l = good;
      l[fl] = 1'($urandom);
      l[fl + 7] = 1'($urandom);
      do_read(l, 7'(1 << fl), b, {good[fl + 7], good[fl]}, "R7 failed lane rebuild");
    end

    // R8 / R9: stall holds the output and blocks the next word
    @(negedge clk);
    out_ready = 1'b0; rd_valid = 1'b1; rd_lanes = ref_lanes(8'hA5); fail_mask = '0;
    @(negedge clk);
    chk(out_valid === 1'b1 && out_byte === 8'hA5, "R9 word A presented", 32'(out_byte), 32'hA5);
    rd_lanes = ref_lanes(8'h3C);
    chk(rd_ready === 1'b0, "R8 rd_ready low when stalled", 32'(rd_ready), 0);
    @(negedge clk);
    chk(out_valid === 1'b1 && out_byte === 8'hA5, "R8 held under stall", 32'(out_byte), 32'hA5);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_byte === 8'h3C, "R8 next word after release", 32'(out_byte), 32'h3C);
    rd_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 out_valid drops when drained", 32'(out_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule